// File: doc/BRIEF.md
# Half-Select Logical Right Shifter

This block takes a 48-bit word and treats it as two independent 24-bit halves. A 9-bit control word picks one half and a shift distance. The chosen half is shifted right logically, with zeros entering at its top. The other half goes to the output exactly as it came in. No bit ever moves from one half into the other.

The block is purely combinational and has no clock or reset. It suits a datapath that packs two 24-bit lanes into one word and needs to normalise or align one lane at a time. The shift is built as a fixed chain of power-of-two mux stages. Its structure is static and does not depend on the shift distance at run time.

Top module: `half_sel_shifter`

## Requirements
- R1: When ctrl_i[8] is 0, data_o[23:0] equals data_i[23:0] shifted right logically by the unsigned amount ctrl_i[7:0].
- R2: When ctrl_i[8] is 1, data_o[47:24] equals data_i[47:24] shifted right logically by the unsigned amount ctrl_i[7:0].
- R3: The half not selected by ctrl_i[8] appears on data_o bit for bit as it is on data_i.
- R4: For a shift amount n from 1 to 23, the top n bits of the selected half of data_o are zero.
- R5: A shift amount of 24 or more (up to 255) drives the selected half of data_o to all zeros.
- R6: A shift amount of 0 makes data_o equal to data_i, whichever half is selected.
- R7: No bit of data_i[47:24] reaches data_o[23:0], and no bit of data_i[23:0] reaches data_o[47:24].
- R8: data_o follows any change of data_i or ctrl_i with no clock, and takes a new value after each input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 48 | Input word: low half [23:0], high half [47:24] |
| ctrl_i | input | 9 | [7:0] shift amount, [8] half select (0 low, 1 high) |
| data_o | output | 48 | Word with the selected half shifted |

## Verification
The assertions are evaluated on every input change. They check the following:
- the untouched half passes through unchanged;
- vacated bits are zero-filled;
- the selected half clears once the amount reaches the half width;
- the word passes through whole at amount zero;
- the selected half never gains set bits, which would happen if bits crossed in from the other half.

The exact shifted value of the selected half at each distance is shown only by the bench. It uses a vector table, a sweep of every amount from 0 to 40 on both halves, and amounts up to 255. Output tracking with no clock is also shown only by the bench: it changes the data while the control is held, then changes the control while the data is held.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int unsigned HALF_W = 24;
  localparam int unsigned AMT_W  = 8;
  localparam int unsigned N_HALF = 2;
endpackage

// File: rtl/hsr_stage.sv
// One mux level: conditional fixed shift by SH with zero fill.
module hsr_stage #(
  parameter int unsigned W  = 24,
  parameter int unsigned SH = 1
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] shifted;

  generate
    if (SH >= W) begin : g_full
      assign shifted = '0;
    end else begin : g_part
      assign shifted = {{SH{1'b0}}, d_i[W-1:SH]};
    end
  endgenerate

  assign q_o = en_i ? shifted : d_i;
endmodule

// File: rtl/hsr_half_shifter.sv
// Log-depth barrel on one half, with saturation to zero and a bypass.
module hsr_half_shifter #(
  parameter int unsigned HALF_W = 24,
  parameter int unsigned AMT_W  = 8
) (
  input  logic              en_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [HALF_W-1:0] d_i,
  output logic [HALF_W-1:0] q_o
);
  localparam int unsigned STG_RAW = $clog2(HALF_W);
  localparam int unsigned STG     = (STG_RAW > AMT_W) ? AMT_W : STG_RAW;

  logic [HALF_W-1:0] chain [STG+1];
  logic              ovf;

  assign chain[0] = d_i;

  generate
    for (genvar k = 0; k < STG; k++) begin : g_stg
      hsr_stage #(
        .W  (HALF_W),
        .SH (1 << k)
      ) u_stage (
        .en_i (amt_i[k]),
        .d_i  (chain[k]),
        .q_o  (chain[k+1])
      );
    end
  endgenerate

  // Distances at or past the half width empty the half.
  assign ovf = (32'(amt_i) >= HALF_W);

  always_comb begin
    if (!en_i)    q_o = d_i;
    else if (ovf) q_o = '0;
    else          q_o = chain[STG];
  end
endmodule

// File: rtl/half_sel_shifter.sv
module half_sel_shifter #(
  parameter int unsigned HALF_W = hsr_pkg::HALF_W,
  parameter int unsigned AMT_W  = hsr_pkg::AMT_W
) (
  input  logic [2*HALF_W-1:0] data_i,
  input  logic [AMT_W:0]      ctrl_i,
  output logic [2*HALF_W-1:0] data_o
);
  localparam int unsigned N_HALF = hsr_pkg::N_HALF;

  logic [AMT_W-1:0] amt;
  logic             sel;

  assign amt = ctrl_i[AMT_W-1:0];
  assign sel = ctrl_i[AMT_W];

  generate
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
      logic en;
      assign en = (sel == 1'(h));
      hsr_half_shifter #(
        .HALF_W (HALF_W),
        .AMT_W  (AMT_W)
      ) u_half (
        .en_i  (en),
        .amt_i (amt),
        .d_i   (data_i[h*HALF_W +: HALF_W]),
        .q_o   (data_o[h*HALF_W +: HALF_W])
      );
    end
  endgenerate
endmodule

// File: rtl/hsr_checker.sv
module hsr_checker #(
  parameter int unsigned HALF_W = 24,
  parameter int unsigned AMT_W  = 8
) (
  input logic [2*HALF_W-1:0] data_i,
  input logic [AMT_W:0]      ctrl_i,
  input logic [2*HALF_W-1:0] data_o
);
  logic [HALF_W-1:0] sel_in, sel_out, keep_in, keep_out;
  int unsigned       amt;
  logic              known;

  always_comb begin
    amt   = 32'(ctrl_i[AMT_W-1:0]);
    known = !$isunknown({data_i, ctrl_i, data_o});
    if (ctrl_i[AMT_W]) begin
      sel_in   = data_i[2*HALF_W-1:HALF_W];
      sel_out  = data_o[2*HALF_W-1:HALF_W];
      keep_in  = data_i[HALF_W-1:0];
      keep_out = data_o[HALF_W-1:0];
    end else begin
      sel_in   = data_i[HALF_W-1:0];
      sel_out  = data_o[HALF_W-1:0];
      keep_in  = data_i[2*HALF_W-1:HALF_W];
      keep_out = data_o[2*HALF_W-1:HALF_W];
    end
  end

  always_comb begin
    if (known) begin
      a_r3_keep_half: assert (keep_out == keep_in)
        else $error("R3 unselected half altered");
      if (amt >= 1 && amt < HALF_W) begin
        a_r4_zero_fill: assert ((sel_out >> (HALF_W - amt)) == '0)
          else $error("R4 vacated bits not zero");
      end
      if (amt >= HALF_W) begin
        a_r5_clear: assert (sel_out == '0)
          else $error("R5 selected half not cleared");
      end
      if (amt == 0) begin
        a_r6_pass: assert (data_o == data_i)
          else $error("R6 zero amount changed word");
      end
      a_r7_no_cross: assert ($countones(sel_out) <= $countones(sel_in))
        else $error("R7 bits entered selected half");
    end
  end
endmodule

bind half_sel_shifter hsr_checker #(
  .HALF_W (HALF_W),
  .AMT_W  (AMT_W)
) u_chk (
  .data_i (data_i),
  .ctrl_i (ctrl_i),
  .data_o (data_o)
);

// File: tb/tb_half_sel_shifter.sv
module tb_half_sel_shifter;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HALF_W     = 24;
  localparam int unsigned W          = 48;
  localparam int unsigned N_VEC      = 13;

  // {data_in, ctrl, expected}
  localparam logic [W+9+W-1:0] VEC [N_VEC] = '{
    {48'hFFFFFF_FFFFFF, 9'h004, 48'hFFFFFF_0FFFFF}, // R1
    {48'hFFFFFF_FFFFFF, 9'h104, 48'h0FFFFF_FFFFFF}, // R2
    {48'h800000_000001, 9'h117, 48'h000001_000001}, // R2 R4
    {48'h123456_ABCDEF, 9'h018, 48'h123456_000000}, // R5
    {48'h123456_ABCDEF, 9'h1FF, 48'h000000_ABCDEF}, // R5
    {48'h123456_ABCDEF, 9'h000, 48'h123456_ABCDEF}, // R6
    {48'h123456_ABCDEF, 9'h100, 48'h123456_ABCDEF}, // R6
    {48'h123456_ABCDEF, 9'h008, 48'h123456_00ABCD}, // R1 R3
    {48'h123456_ABCDEF, 9'h10C, 48'h000123_ABCDEF}, // R2 R3
    {48'h000001_800000, 9'h001, 48'h000001_400000}, // R7
    {48'h000001_800000, 9'h101, 48'h000000_800000}, // R7
    {48'hFFFFFF_FFFFFF, 9'h017, 48'hFFFFFF_000001}, // R4
    {48'hFFFFFF_FFFFFF, 9'h0FF, 48'hFFFFFF_000000}  // R5
  };

  logic [W-1:0] data_i;
  logic [8:0]   ctrl_i;
  logic [W-1:0] data_o;

  int checks   = 0;
  int failures = 0;

  half_sel_shifter dut (
    .data_i (data_i),
    .ctrl_i (ctrl_i),
    .data_o (data_o)
  );

  function automatic logic [W-1:0] ref_shift(input logic [W-1:0] d, input logic [8:0] c);
    logic [HALF_W-1:0] lo, hi;
    int unsigned a;
    lo = d[HALF_W-1:0];
    hi = d[W-1:HALF_W];
    a  = 32'(c[7:0]);
    if (c[8]) hi = (a >= HALF_W) ? '0 : (hi >> a);
    else      lo = (a >= HALF_W) ? '0 : (lo >> a);
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (data_o !== exp) begin
      failures++;
      $display("FAIL %s ctrl=%h data_i=%h actual=%h expected=%h",
               req, ctrl_i, data_i, data_o, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic [8:0] c);
    data_i = d;
    ctrl_i = c;
    #(CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Idle state: all-zero inputs give all-zero output.
    apply('0, '0);
    check("R6 idle", '0);

    for (int i = 0; i < N_VEC; i++) begin
      apply(VEC[i][W+9+W-1:W+9], VEC[i][W+8:W]);
      check("R1/R2 vector table", VEC[i][W-1:0]);
    end

    // Full sweep of both halves against the reference model.
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a <= 40; a++) begin
        apply(48'hA5C3F1_9E7B2D, {1'(s), 8'(a)});
        check(s == 0 ? "R1 sweep" : "R2 sweep", ref_shift(48'hA5C3F1_9E7B2D, {1'(s), 8'(a)}));
      end
    end

    // R3: unselected half keeps arbitrary content at the largest amount.
    apply(48'hDEADBE_EF0123, 9'h1FF);
    check("R3 low kept", 48'h000000_EF0123);
    apply(48'hDEADBE_EF0123, 9'h0FF);
    check("R3 high kept", 48'hDEADBE_000000);

    // R7: set bits adjacent to the boundary must not cross.
    apply(48'h000001_000000, 9'h001);
    check("R7 high lsb not into low", 48'h000001_000000);
    apply(48'h000000_FFFFFF, 9'h110);
    check("R7 low not into high", 48'h000000_FFFFFF);

    // R8: output tracks data change with control held, then control change.
    apply(48'h000000_0000F0, 9'h004);
    check("R8 first", 48'h000000_00000F);
    apply(48'h000000_000F00, 9'h004);
    check("R8 data change", 48'h000000_0000F0);
    apply(48'h000000_000F00, 9'h008);
    check("R8 ctrl change", 48'h000000_00000F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule